// File: doc/BRIEF.md
# Vectored Interrupt Controller with Cascade Input

This controller gathers 32 level-sensitive interrupt request lines and drives two processor interrupt outputs: a fast one and a normal one. Each source has an enable bit and a route bit that picks the fast or the normal output. Requests are never stored inside the controller; both outputs are combinational functions of the current request levels and the programmed masks. Masking and request generation therefore need no clock, so a source can wake a system whose clock is halted.

For the normal interrupt, sixteen vector slots each bind one source number to a handler address. The lowest-numbered enabled slot whose source is pending on the normal path supplies the vector. When no slot matches, a cascade input from a second controller supplies its vector if it is requesting, and otherwise a programmable default vector is returned. Reading the vector register marks the returned priority level as in service: afterwards only strictly more urgent slots can return a vector, which allows nested handlers. Writing the vector register ends the most urgent level in service. Two controllers are chained by wiring the downstream `irq_out` and `vec_out` to the upstream `chain_irq` and `chain_vec`.

Software reaches the controller through a plain register bus: 32-bit data, writes take effect at the clock edge where `bus_wr` is high, and read data appears on `bus_rdata` one cycle after `bus_rd` and holds until the next read. All of these are control pins with no back-pressure; the block never stalls the bus.

Top module: `vic_top`

## Requirements
- R1: While reset is low and right after it, every enable bit is 0, so `irq_out` and `fiq_out` stay low whatever `src_req` is; the enable register reads 0.
- R2: A source reaches an output only while its enable bit is set. A write to word address 4 sets the enable bits that are 1 in the data; a write to word address 5 clears them; other bits keep their value. Both addresses read back the enable register.
- R3: The route register at word address 3 sends a source to `fiq_out` when its bit is 1 and to `irq_out` when 0; word address 2 reads the fast-routed pending sources (request AND enable AND route).
- R4: `irq_out` and `fiq_out` follow changes of `src_req` with no clock edge, and fall as soon as the request drops.
- R5: Word address 0 reads the raw request lines and word address 1 the normal-path pending sources (request AND enable AND NOT route), one cycle after `bus_rd`.
- R6: A read of word address 6 returns the handler address of the lowest-numbered enabled slot whose source is pending on the normal path; fast-routed sources never select a slot. Slot handler addresses live at word addresses 8 to 23 (slot 0 first).
- R7: When the normal path is pending but no slot matches and `chain_irq` is low, the vector read returns the default vector held at word address 7.
- R8: `chain_irq` high forces `irq_out` high; with no matching local slot the vector read returns `chain_vec`, while any matching local slot wins over the cascade.
- R9: A vector read marks the returned level in service (slot number, or one level below all slots for cascade and default). While a level is in service, only lower-numbered slots may return a vector; otherwise the default vector is returned and nothing is marked. A write to word address 6 ends the most urgent level in service.
- R10: The slot control words at word addresses 24 to 39 hold the source number in bits 4 to 0 and the slot enable in bit 5; a disabled slot never matches. They read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register bus and in-service state |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 32 | Level-sensitive interrupt request lines |
| bus_addr | input | 6 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| chain_irq | input | 1 | Normal request from a downstream controller |
| chain_vec | input | 32 | Vector from a downstream controller |
| irq_out | output | 1 | Normal processor interrupt |
| fiq_out | output | 1 | Fast processor interrupt |
| vec_out | output | 32 | Current vector, for feeding an upstream controller |

## Verification
The request lines are driven with sources that are disabled, enabled on the normal path, and routed to the fast path, which separates masking faults from routing faults; a stretch with the clock stopped shows that the outputs do not depend on a clock edge. Vector reads are tried with two slots pending at once, with a more urgent slot arriving during service, with a fast-routed source that owns a slot, with a disabled slot, and with only the cascade requesting, so that slot order, default fallback and cascade precedence each give a different expected address. Repeated reads and acknowledge writes walk the in-service levels up and down to tell correct nesting from a stack that never pops or never blocks.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int REG_AW = 6;
  localparam logic [REG_AW-1:0] A_RAW    = 6'd0;
  localparam logic [REG_AW-1:0] A_IRQST  = 6'd1;
  localparam logic [REG_AW-1:0] A_FIQST  = 6'd2;
  localparam logic [REG_AW-1:0] A_ROUTE  = 6'd3;
  localparam logic [REG_AW-1:0] A_ENSET  = 6'd4;
  localparam logic [REG_AW-1:0] A_ENCLR  = 6'd5;
  localparam logic [REG_AW-1:0] A_VEC    = 6'd6;
  localparam logic [REG_AW-1:0] A_DEFV   = 6'd7;
  localparam logic [REG_AW-1:0] A_SLOTV  = 6'd8;
endpackage

// File: rtl/vic_lowest.sv
module vic_lowest #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vic_slot_match.sv
module vic_slot_match #(
  parameter int NSRC = 32,
  parameter int SW   = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] pend,
  input  logic            slot_en,
  input  logic [SW-1:0]   slot_src,
  output logic            hit
);
  assign hit = slot_en & pend[slot_src];
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int DW    = 32,
  parameter int VW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_req,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              chain_irq,
  input  logic [VW-1:0]     chain_vec,
  output logic              irq_out,
  output logic              fiq_out,
  output logic [VW-1:0]     vec_out
);
  localparam int SW      = $clog2(NSRC);
  localparam int SIW     = $clog2(NSLOT);
  localparam int LW      = NSLOT + 1;
  localparam int LIW     = $clog2(LW);
  localparam int DEF_LVL = NSLOT;
  localparam logic [REG_AW-1:0] A_SLOTC = A_SLOTV + REG_AW'(NSLOT);
  localparam logic [REG_AW-1:0] A_END   = A_SLOTC + REG_AW'(NSLOT);

  logic [NSRC-1:0] en_q, sel_q;
  logic [VW-1:0]   def_q;
  logic [VW-1:0]   slot_vec_q [NSLOT];
  logic [NSLOT-1:0] slot_en_q;
  logic [SW-1:0]   slot_src_q [NSLOT];
  logic [LW-1:0]   insvc_q;
  logic [DW-1:0]   rdata_q;

  logic [NSRC-1:0] irq_pend, fiq_pend;
  assign irq_pend = src_req & en_q & ~sel_q;
  assign fiq_pend = src_req & en_q & sel_q;
  assign irq_out  = (|irq_pend) | chain_irq;
  assign fiq_out  = |fiq_pend;

  // current service level
  logic           svc_busy;
  logic [LIW-1:0] svc_lvl;
  vic_lowest #(.N(LW), .IW(LIW)) u_lvl (.req(insvc_q), .found(svc_busy), .idx(svc_lvl));

  // per-slot match and eligibility
  logic [NSLOT-1:0] slot_hit, slot_ok;
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    vic_slot_match #(.NSRC(NSRC), .SW(SW)) u_match (
      .pend(irq_pend), .slot_en(slot_en_q[g]), .slot_src(slot_src_q[g]), .hit(slot_hit[g]));
    assign slot_ok[g] = slot_hit[g] && (!svc_busy || (g < int'(svc_lvl)));
  end

  logic           win_found;
  logic [SIW-1:0] win_idx;
  vic_lowest #(.N(NSLOT), .IW(SIW)) u_win (.req(slot_ok), .found(win_found), .idx(win_idx));

  logic chain_sel, def_mark;
  assign chain_sel = chain_irq && !svc_busy && !win_found;
  assign def_mark  = !svc_busy && !win_found && ((|irq_pend) || chain_irq);

  always_comb begin
    if (win_found)      vec_out = slot_vec_q[win_idx];
    else if (chain_sel) vec_out = chain_vec;
    else                vec_out = def_q;
  end

  // bus decode
  logic [REG_AW-1:0] off_v, off_c;
  logic              in_v, in_c;
  assign off_v = bus_addr - A_SLOTV;
  assign off_c = bus_addr - A_SLOTC;
  assign in_v  = (bus_addr >= A_SLOTV) && (bus_addr < A_SLOTC);
  assign in_c  = (bus_addr >= A_SLOTC) && (bus_addr < A_END);

  logic [DW-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (in_v)      rd_word = DW'(slot_vec_q[off_v[SIW-1:0]]);
    else if (in_c) rd_word = DW'({slot_en_q[off_c[SIW-1:0]], slot_src_q[off_c[SIW-1:0]]});
    else begin
      case (bus_addr)
        A_RAW:            rd_word = DW'(src_req);
        A_IRQST:          rd_word = DW'(irq_pend);
        A_FIQST:          rd_word = DW'(fiq_pend);
        A_ROUTE:          rd_word = DW'(sel_q);
        A_ENSET, A_ENCLR: rd_word = DW'(en_q);
        A_VEC:            rd_word = DW'(vec_out);
        A_DEFV:           rd_word = DW'(def_q);
        default:          rd_word = '0;
      endcase
    end
  end

  // in-service update: acknowledge pops the most urgent level, vector read marks
  logic [LW-1:0] insvc_nx;
  always_comb begin
    insvc_nx = insvc_q;
    if (bus_wr && bus_addr == A_VEC) insvc_nx = insvc_q & (insvc_q - LW'(1));
    if (bus_rd && bus_addr == A_VEC) begin
      if (win_found)     insvc_nx[win_idx] = 1'b1;
      else if (def_mark) insvc_nx[DEF_LVL] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      sel_q     <= '0;
      def_q     <= '0;
      slot_en_q <= '0;
      insvc_q   <= '0;
      rdata_q   <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        slot_vec_q[i] <= '0;
        slot_src_q[i] <= '0;
      end
    end else begin
      insvc_q <= insvc_nx;
      if (bus_rd) rdata_q <= rd_word;
      if (bus_wr) begin
        if (in_v) slot_vec_q[off_v[SIW-1:0]] <= bus_wdata[VW-1:0];
        else if (in_c) begin
          slot_src_q[off_c[SIW-1:0]] <= bus_wdata[SW-1:0];
          slot_en_q[off_c[SIW-1:0]]  <= bus_wdata[SW];
        end else begin
          case (bus_addr)
            A_ROUTE: sel_q <= bus_wdata[NSRC-1:0];
            A_ENSET: en_q  <= en_q | bus_wdata[NSRC-1:0];
            A_ENCLR: en_q  <= en_q & ~bus_wdata[NSRC-1:0];
            A_DEFV:  def_q <= bus_wdata[VW-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/vic_chk.sv
module vic_chk
  import vic_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int LW   = 17,
  parameter int DW   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   src_req,
  input logic [REG_AW-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic              chain_irq,
  input logic              irq_out,
  input logic              fiq_out,
  input logic [NSRC-1:0]   en_q,
  input logic [LW-1:0]     insvc_q
);
  p_reset_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> en_q == '0);

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (((src_req & en_q) == '0) && !chain_irq) |-> (!irq_out && !fiq_out));

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ENSET) |=> en_q == ($past(en_q) | $past(bus_wdata[NSRC-1:0])));

  p_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ENCLR) |=> en_q == ($past(en_q) & ~$past(bus_wdata[NSRC-1:0])));

  p_fiqst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_FIQST) |=> ((bus_rdata[NSRC-1:0] != '0) == $past(fiq_out)));

  p_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_RAW) |=> bus_rdata[NSRC-1:0] == $past(src_req));

  p_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chain_irq |-> irq_out);

  p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_addr == A_VEC && insvc_q != '0)
      |=> $countones(insvc_q) == $countones($past(insvc_q)) - 1);
endmodule

bind vic_top vic_chk #(.NSRC(NSRC), .LW(NSLOT + 1), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .chain_irq(chain_irq), .irq_out(irq_out), .fiq_out(fiq_out),
  .en_q(en_q), .insvc_q(insvc_q));

// File: tb/vic_top_test.sv
module vic_top_test;
  import vic_pkg::*;

  logic        clk = 1'b0;
  logic        clk_run = 1'b1;
  logic        rst_n = 1'b0;
  logic [31:0] src_req = '0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        chain_irq = 1'b0;
  logic [31:0] chain_vec = '0;
  logic        irq_out, fiq_out;
  logic [31:0] vec_out;

  int checks = 0, failures = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  logic rd_seen = 1'b0;

  vic_top uut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chain_irq(chain_irq), .chain_vec(chain_vec),
    .irq_out(irq_out), .fiq_out(fiq_out), .vec_out(vec_out));

  initial forever begin
    #4;
    if (clk_run) clk = ~clk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read data one cycle after each read strobe
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
      else begin
        item_t it;
        it = sb.pop_front();
        chk(it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pins(input logic ei, input logic ef, input string tag);
    #1;
    chk({tag, " irq_out"}, 32'(irq_out), 32'(ei));
    chk({tag, " fiq_out"}, 32'(fiq_out), 32'(ef));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    src_req = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    pins(1'b0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    pins(1'b0, 1'b0, "R1 after reset");
    rd(A_ENSET, 32'h0, "R1 enable after reset");
    rd(A_RAW, 32'hFFFF_FFFF, "R5 raw status");
    src_req = '0;

    // R2 set/clear
    wr(A_ENSET, 32'h0000_00F0);
    wr(A_ENSET, 32'h0000_0003);
    wr(A_ENCLR, 32'h0000_0010);
    rd(A_ENSET, 32'h0000_00E3, "R2 enable via set addr");
    rd(A_ENCLR, 32'h0000_00E3, "R2 enable via clear addr");
    src_req = 32'h0000_0100;
    pins(1'b0, 1'b0, "R2 disabled source");
    rd(A_IRQST, 32'h0, "R5 masked normal status");

    // R3 routing
    src_req = 32'h0000_0002;
    pins(1'b1, 1'b0, "R3 normal route");
    rd(A_IRQST, 32'h2, "R5 normal pending");
    wr(A_ROUTE, 32'h0000_0002);
    pins(1'b0, 1'b1, "R3 fast route");
    rd(A_FIQST, 32'h2, "R3 fast status");
    rd(A_IRQST, 32'h0, "R3 normal status empty");
    wr(A_ROUTE, 32'h0);

    // R4 no clock needed
    src_req = 32'h1;
    @(negedge clk);
    clk_run = 1'b0;
    #2;
    pins(1'b1, 1'b0, "R4 level high");
    src_req = 32'h0;
    #2;
    pins(1'b0, 1'b0, "R4 level dropped");
    src_req = 32'h1;
    #2;
    pins(1'b1, 1'b0, "R4 level again");
    src_req = 32'h0;
    #2;
    clk_run = 1'b1;

    // slot setup: slot0 -> src7, slot3 -> src1, slot5 -> src5
    wr(6'd8,  32'h1000_0000);
    wr(6'd11, 32'h1000_0300);
    wr(6'd13, 32'h1000_0500);
    wr(6'd24, 32'h0000_0027);
    wr(6'd27, 32'h0000_0021);
    wr(6'd29, 32'h0000_0025);
    wr(A_DEFV, 32'hDEF0_0000);
    rd(6'd27, 32'h0000_0021, "R10 slot control readback");
    rd(6'd13, 32'h1000_0500, "R6 slot address readback");

    // R6 priority and R9 nesting
    src_req = 32'h0000_0022;
    rd(A_VEC, 32'h1000_0300, "R6 lowest slot wins");
    src_req = 32'h0000_00A2;
    rd(A_VEC, 32'h1000_0000, "R9 more urgent preempts");
    rd(A_VEC, 32'hDEF0_0000, "R9 nothing more urgent");
    wr(A_VEC, 32'h0);
    rd(A_VEC, 32'h1000_0000, "R9 after one ack");
    wr(A_VEC, 32'h0);
    wr(A_VEC, 32'h0);
    src_req = 32'h0000_0020;
    @(negedge clk);
    #1;
    chk("R6 vec_out pin", vec_out, 32'h1000_0500);
    rd(A_VEC, 32'h1000_0500, "R6 single slot");
    wr(A_VEC, 32'h0);

    // R7 default
    src_req = 32'h0000_0040;
    rd(A_VEC, 32'hDEF0_0000, "R7 unvectored source");
    wr(A_VEC, 32'h0);

    // R6 fast-routed source owns slot5 but gives no vector
    wr(A_ROUTE, 32'h0000_0020);
    src_req = 32'h0000_0020;
    pins(1'b0, 1'b1, "R6 fast source pins");
    rd(A_VEC, 32'hDEF0_0000, "R6 fast source no slot");
    wr(A_ROUTE, 32'h0);

    // R10 disabled slot
    wr(6'd29, 32'h0000_0005);
    rd(A_VEC, 32'hDEF0_0000, "R10 disabled slot");
    wr(A_VEC, 32'h0);

    // R8 cascade
    src_req = 32'h0;
    chain_vec = 32'hC0C0_0000;
    chain_irq = 1'b1;
    pins(1'b1, 1'b0, "R8 cascade request");
    rd(A_VEC, 32'hC0C0_0000, "R8 cascade vector");
    wr(A_VEC, 32'h0);
    src_req = 32'h0000_0002;
    rd(A_VEC, 32'h1000_0300, "R8 local slot beats cascade");
    wr(A_VEC, 32'h0);
    chain_irq = 1'b0;
    src_req = 32'h0;
    rd(A_VEC, 32'hDEF0_0000, "R7 idle default");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) chk("scoreboard drained", 32'(sb.size()), 32'd0);
    finish_run();
  end
endmodule